// File: doc/BRIEF.md
# Dual-Encoding Trace Pin Serializer

This block takes trace bytes from a valid/ready byte stream and sends them out on one output pin. Software picks one of two line codes at run time: a Manchester code with a mid-bit transition, or an asynchronous, UART-style NRZ frame. A programmable prescaler sets the symbol period in input clocks. Manchester is the encoding after reset.

The output pin is shared with the JTAG test-data-out function. A mode input tells the block when the pin is in use for JTAG debug. While it is, the block releases the pin's output enable and takes no new bytes. Any byte offered during that time stays upstream and is sent once the pin is free again.

Each byte is turned into a row of line symbols. Each symbol lasts (prescaler + 1) clocks. The encoding and the prescaler are captured when a byte is accepted, so a register write only changes the next byte.

Top module: `trace_pin_serializer`

## Requirements
- R1: After reset the encoding is Manchester, the pin idles low, `pin_oe` is 1 and `in_ready` is 1 while `jtag_mode` is 0.
- R2: A write with `cfg_sel`=0 sets the protocol. The value 2 selects NRZ. Any other value (for example 0, 1 or 3) selects Manchester.
- R3: Every line symbol lasts exactly (prescaler + 1) clock cycles. The prescaler is written with `cfg_sel`=1.
- R4: An NRZ frame has 10 symbols: a 0 start symbol, then data bits 0 through 7 (LSB first, each as its own level), then a 1 stop symbol. The NRZ idle level is 1.
- R5: A Manchester frame has 18 symbols. The first bit is a marker with the value 1, and then data bits 0 through 7 follow, LSB first. Each bit is two symbols: a 1 is sent as high then low, and a 0 as low then high. The Manchester idle level is 0.
- R6: The first symbol of a frame appears in the cycle after the handshake. `in_ready` is 0 for the whole frame and is 1 again in the first cycle after its last symbol.
- R7: While `jtag_mode` is 1, `pin_oe` and `in_ready` are 0. A byte held on the input during that time is sent unchanged after `jtag_mode` returns to 0.
- R8: A prescaler write during a frame leaves that frame's timing unchanged. It applies from the next accepted byte.
- R9: A protocol write during a frame lets that frame finish in the old encoding. The idle level and the next frame follow the new encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | DATA_W | Trace byte to send |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 protocol, 1 prescaler |
| cfg_wdata | input | PRESC_W | Register write data |
| jtag_mode | input | 1 | 1 while the pin is in use for JTAG test-data-out |
| pin_out | output | 1 | Serial line level |
| pin_oe | output | 1 | Output enable for the shared pin |

## Verification
The bench sweeps prescaler values 0 to 2 in both encodings. For each combination it sends the bytes 00, FF, A5, 5A, 01 and 80 and compares every cycle of every symbol with a frame computed in the bench. All-zero and all-one bytes show whether the start, stop and marker symbols are framed correctly. Alternating bytes and single-bit bytes expose bit order and half-bit polarity errors. Further cases write the registers in the middle of a frame, which separates settings latched per byte from live settings. Holding a byte during JTAG mode shows whether it is stalled or lost.

// File: rtl/trace_pin_pkg.sv
package trace_pin_pkg;
   typedef enum logic {
      ENC_MANCH = 1'b0,
      ENC_NRZ   = 1'b1
   } enc_e;

   localparam int unsigned PROTO_NRZ_CODE = 2;
endpackage

// File: rtl/trace_pin_baud.sv
module trace_pin_baud #(
   parameter int unsigned PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc_in,
   output logic               tick
);
   logic [PRESC_W-1:0] presc_act;
   logic [PRESC_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_act <= '0;
         cnt       <= '0;
      end else if (load) begin
         presc_act <= presc_in;
         cnt       <= presc_in;
      end else if (run) begin
         cnt <= (cnt == '0) ? presc_act : cnt - 1'b1;
      end
   end

   assign tick = run && (cnt == '0);

   // R3: the down-counter never leaves the window set at byte start
   p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt <= presc_act);
endmodule

// File: rtl/trace_pin_framer.sv
module trace_pin_framer
   import trace_pin_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SYM_W  = 2 * (DATA_W + 1),
   parameter int unsigned IDX_W  = $clog2(SYM_W)
) (
   input  logic [DATA_W-1:0] data,
   input  enc_e              enc,
   output logic [SYM_W-1:0]  syms,
   output logic [IDX_W-1:0]  last_idx
);
   logic [SYM_W-1:0] man_syms;
   logic [SYM_W-1:0] nrz_syms;

   for (genvar i = 0; i <= DATA_W; i++) begin : g_man
      if (i == 0) begin : g_marker
         assign man_syms[1:0] = 2'b01;
      end else begin : g_bit
         assign man_syms[2*i]   = data[i-1];
         assign man_syms[2*i+1] = ~data[i-1];
      end
   end

   assign nrz_syms[0] = 1'b0;
   for (genvar i = 0; i < DATA_W; i++) begin : g_nrz
      assign nrz_syms[i+1] = data[i];
   end
   assign nrz_syms[SYM_W-1:DATA_W+1] = '1;

   assign syms     = (enc == ENC_NRZ) ? nrz_syms : man_syms;
   assign last_idx = (enc == ENC_NRZ) ? IDX_W'(DATA_W + 1) : IDX_W'(SYM_W - 1);
endmodule

// File: rtl/trace_pin_serializer.sv
module trace_pin_serializer
   import trace_pin_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PRESC_W   = 8,
   parameter int unsigned PRESC_RST = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  in_data,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic               cfg_wr,
   input  logic               cfg_sel,
   input  logic [PRESC_W-1:0] cfg_wdata,
   input  logic               jtag_mode,
   output logic               pin_out,
   output logic               pin_oe
);
   localparam int unsigned SYM_W    = 2 * (DATA_W + 1);
   localparam int unsigned IDX_W    = $clog2(SYM_W);
   localparam int unsigned NRZ_SYMS = DATA_W + 2;

   if (PRESC_W < 2) begin : g_bad_presc_w
      $error("PRESC_W must hold the protocol code 2");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be at least 1");
   end
   if (PRESC_RST >= (1 << PRESC_W)) begin : g_bad_presc_rst
      $error("PRESC_RST does not fit in PRESC_W");
   end

   enc_e               enc_sel;
   enc_e               enc_act;
   logic [PRESC_W-1:0] presc_reg;
   logic               busy;
   logic [SYM_W-1:0]   sym_sr;
   logic [IDX_W-1:0]   left;
   logic [SYM_W-1:0]   frame;
   logic [IDX_W-1:0]   frame_last;
   logic               load;
   logic               tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enc_sel   <= ENC_MANCH;
         presc_reg <= PRESC_W'(PRESC_RST);
      end else if (cfg_wr) begin
         if (cfg_sel == 1'b0)
            enc_sel <= (cfg_wdata == PRESC_W'(PROTO_NRZ_CODE)) ? ENC_NRZ : ENC_MANCH;
         else
            presc_reg <= cfg_wdata;
      end
   end

   assign in_ready = !busy && !jtag_mode;
   assign load     = in_valid && in_ready;

   trace_pin_framer #(.DATA_W(DATA_W), .SYM_W(SYM_W), .IDX_W(IDX_W)) framer_i (
      .data     (in_data),
      .enc      (enc_sel),
      .syms     (frame),
      .last_idx (frame_last)
   );

   trace_pin_baud #(.PRESC_W(PRESC_W)) baud_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .run      (busy),
      .presc_in (presc_reg),
      .tick     (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         enc_act <= ENC_MANCH;
         sym_sr  <= '0;
         left    <= '0;
      end else if (load) begin
         busy    <= 1'b1;
         enc_act <= enc_sel;
         sym_sr  <= frame;
         left    <= frame_last;
      end else if (tick) begin
         if (left == '0) begin
            busy <= 1'b0;
         end else begin
            sym_sr <= {1'b0, sym_sr[SYM_W-1:1]};
            left   <= left - 1'b1;
         end
      end
   end

   assign pin_out = busy ? sym_sr[0] : (enc_sel == ENC_NRZ);
   assign pin_oe  = !jtag_mode;

   // R3: a symbol holds until the baud tick
   p_symbol_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(pin_out));
   // R4: an NRZ frame opens with a low start symbol
   p_nrz_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && enc_act == ENC_NRZ) |-> !pin_out);
   // R4: an NRZ frame never counts more symbols than start, data and stop
   p_nrz_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && enc_act == ENC_NRZ) |-> left <= IDX_W'(NRZ_SYMS - 1));
   // R5: a Manchester frame opens with the high half of the marker
   p_manch_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && enc_act == ENC_MANCH) |-> pin_out);
   // R4: the last NRZ symbol is the high stop level
   p_nrz_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && enc_act == ENC_NRZ && left == '0) |-> pin_out);
endmodule

// File: tb/trace_pin_serializer_tb.sv
module trace_pin_serializer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       cfg_wr = 1'b0;
   logic       cfg_sel = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       jtag_mode = 1'b0;
   logic       pin_out;
   logic       pin_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   trace_pin_serializer #(.DATA_W(8), .PRESC_W(8), .PRESC_RST(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .jtag_mode(jtag_mode), .pin_out(pin_out),
      .pin_oe(pin_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_sym(input logic [7:0] b, input bit nrz, input int k);
      int  j;
      logic v;
      if (nrz) begin
         if (k == 0) return 1'b0;
         if (k == 9) return 1'b1;
         return b[k-1];
      end
      j = k / 2;
      v = (j == 0) ? 1'b1 : b[j-1];
      return (k % 2 == 0) ? v : ~v;
   endfunction

   task automatic cfg_write(input bit sel, input logic [7:0] val);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic check_idle(input logic lvl, input string req);
      @(negedge clk);
      chk(pin_out === lvl, req, int'(pin_out), int'(lvl));
      chk(in_ready === 1'b1, req, int'(in_ready), 1);
   endtask

   // Sends one byte, compares every cycle of every symbol, optionally
   // writes a register in the first cycle of the frame.
   task automatic send(input logic [7:0] b, input bit nrz, input int p,
                       input bit mw, input bit msel, input logic [7:0] mval,
                       input string req);
      int nsym;
      int n;
      nsym = nrz ? 10 : 18;
      n = 0;
      @(negedge clk);
      in_data = b; in_valid = 1'b1;
      while (in_ready !== 1'b1) @(negedge clk);
      @(posedge clk);
      for (int k = 0; k < nsym; k++) begin
         for (int c = 0; c <= p; c++) begin
            @(negedge clk);
            if (n == 0) begin
               in_valid = 1'b0;
               if (mw) begin
                  cfg_wr = 1'b1; cfg_sel = msel; cfg_wdata = mval;
               end
            end else begin
               cfg_wr = 1'b0;
            end
            n++;
            chk(pin_out === exp_sym(b, nrz, k), req, int'(pin_out),
                int'(exp_sym(b, nrz, k)));
            chk(in_ready === 1'b0, "R6 ready low in frame", int'(in_ready), 0);
         end
      end
      cfg_wr = 1'b0;
   endtask

   initial begin
      logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pin_out === 1'b0, "R1 idle low", int'(pin_out), 0);
      chk(pin_oe === 1'b1, "R1 oe", int'(pin_oe), 1);
      chk(in_ready === 1'b1, "R1 ready", int'(in_ready), 1);

      // R1 R5: default Manchester with reset prescaler 0
      send(8'hA5, 1'b0, 0, 1'b0, 1'b0, 8'h0, "R5 default manchester");
      check_idle(1'b0, "R6 R5 idle after frame");

      // R2: protocol codes
      cfg_write(1'b0, 8'd2);  check_idle(1'b1, "R2 code 2 nrz");
      cfg_write(1'b0, 8'd3);  check_idle(1'b0, "R2 code 3 manchester");
      cfg_write(1'b0, 8'd2);  check_idle(1'b1, "R2 code 2 nrz again");
      cfg_write(1'b0, 8'd0);  check_idle(1'b0, "R2 code 0 manchester");

      // R3 R4 R5: sweep
      for (int p = 0; p <= 2; p++) begin
         for (int m = 0; m < 2; m++) begin
            cfg_write(1'b1, 8'(p));
            cfg_write(1'b0, (m == 1) ? 8'd2 : 8'd1);
            check_idle(m == 1, "R4 R5 idle level");
            for (int i = 0; i < 6; i++) begin
               send(pats[i], m == 1, p, 1'b0, 1'b0, 8'h0,
                    (m == 1) ? "R4 R3 nrz frame" : "R5 R3 manchester frame");
            end
            check_idle(m == 1, "R6 ready after frame");
         end
      end

      // R8: prescaler written mid-frame (NRZ, p=1 -> 3)
      cfg_write(1'b0, 8'd2);
      cfg_write(1'b1, 8'd1);
      send(8'hC3, 1'b1, 1, 1'b1, 1'b1, 8'd3, "R8 old prescaler kept");
      send(8'h96, 1'b1, 3, 1'b0, 1'b0, 8'h0, "R8 new prescaler next byte");

      // R9: protocol written mid-frame (NRZ -> Manchester)
      send(8'h5A, 1'b1, 3, 1'b1, 1'b0, 8'd1, "R9 old encoding kept");
      check_idle(1'b0, "R9 idle follows new encoding");
      send(8'h5A, 1'b0, 3, 1'b0, 1'b0, 8'h0, "R9 next frame new encoding");

      // R7: pin owned by JTAG, byte held upstream
      cfg_write(1'b1, 8'd0);
      @(negedge clk);
      jtag_mode = 1'b1; in_data = 8'h3C; in_valid = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(pin_oe === 1'b0, "R7 oe released", int'(pin_oe), 0);
         chk(in_ready === 1'b0, "R7 ready low", int'(in_ready), 0);
      end
      jtag_mode = 1'b0;
      send(8'h3C, 1'b0, 0, 1'b0, 1'b0, 8'h0, "R7 held byte sent");
      chk(pin_oe === 1'b1, "R7 oe restored", int'(pin_oe), 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule